// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is a single peripheral DMA channel that alternates between two buffer slots, A and B. Each slot holds a start address and a byte count. While the channel runs, a peripheral raises a request level and the channel moves one burst between memory and the peripheral for each granted request. The memory side is a simple request/acknowledge port that reports the burst address, its byte size and the direction. When the active slot's count reaches zero, the channel marks that slot done. If the other slot is armed, it switches to it with no idle gap. Otherwise it stops and waits.

Software drives the channel through a small register window. It holds a transfer-configuration register, a status register and the four slot registers. The status register has three views. One reads it. One sets bits by writing ones. One clears bits by writing ones. Because of this, software can arm a slot or acknowledge a done flag without a read-modify-write race against the hardware. While one slot drains, software refills the idle one, so a stream can run on indefinitely with the interrupt paced by slot completions.

Top module: `pingpong_dma_chan`

## Requirements
- R1: After reset every register reads zero: configuration, status, both slot addresses and both slot counts. `irq` and `mem_req` are low, and slot A is the slot in use.
- R2: The configuration register at offset 0x00 keeps all 32 bits written. Slot A start (0x10) and slot B start (0x18) read back with address bits 1:0 forced to zero. Slot A count (0x14) and slot B count (0x1C) keep only bits 12:0, so the largest count is 0x1FFF.
- R3: The status register reads at 0x0C with this layout: bit0 run, bit1 interrupt enable, bit2 error, bit3 slot-A done, bit4 slot-A armed, bit5 slot-B done, bit6 slot-B armed, bit7 slot in use (0 = A, 1 = B). A write to 0x04 sets every bit 6:0 written as one. A write to 0x08 clears every bit 6:0 written as one. Zero bits have no effect, and bit7 cannot be written. Offsets 0x04 and 0x08 read as zero.
- R4: The burst size in bytes is 4 or 8 units (configuration bit2 = 1 selects 8), times a unit of 1 or 2 bytes (bit3 = 1 selects 2). A burst never carries more bytes than the slot has left. `mem_write` equals configuration bit0 (1 = device to memory). A pending `mem_req` holds its address and size stable until `mem_ack`.
- R5: A burst starts only while `per_req` is high. Each acknowledged burst without error pulses `per_ack` for one cycle. It advances the slot address by the burst's byte count and lowers the slot count by the same amount, so a slot of N bytes takes ceil(N / burst size) bursts.
- R6: When a slot's count reaches zero, its done bit sets and its armed bit clears. A slot armed with a zero count completes this way without any burst.
- R7: On completion, the in-use bit toggles if the other slot is armed, and transfers go on from that slot. If it is not armed, the in-use bit stays and no further `mem_req` is raised.
- R8: Clearing run stops new bursts. A burst already requested still finishes. Setting run again resumes from the slot's current address and count.
- R9: A burst acknowledged with `mem_err` high sets the error bit and clears run. It neither advances the slot nor pulses `per_ack`.
- R10: `irq` is high exactly when interrupt enable is set and at least one of error, slot-A done or slot-B done is set. Writing those bits to the clear view drops it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Register byte offset, used for both reads and writes |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_addr` (combinational) |
| per_req | input | 1 | Peripheral is ready for a burst (level) |
| per_ack | output | 1 | One-cycle pulse when a burst completes without error |
| mem_req | output | 1 | Memory burst request, held until `mem_ack` |
| mem_addr | output | AW | Memory address of the burst |
| mem_bytes | output | 5 | Byte count of the burst (1 to 16) |
| mem_write | output | 1 | 1 = write memory (device to memory), 0 = read memory |
| mem_ack | input | 1 | Memory completes the pending burst |
| mem_err | input | 1 | Error response, qualified by `mem_ack` |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check these behaviours. A pending memory request does not change address or size before it is acknowledged, and its size is legal. A new request never follows a cycle with run low. No slot is ever advanced past its remaining count. A hardware completion or error wins over a software write to the status register in the same cycle. Other behaviours need whole scenarios. These are the burst sequence over every burst-size setting and many slot lengths, including zero and partial tails. They also cover the hop between slots in either starting order, pause and resume in the middle of a slot, and error recovery. The bench shows these through its memory responder and reference model.

// File: rtl/pingpong_dma_pkg.sv
package pingpong_dma_pkg;

    // register window offsets
    localparam logic [4:0] OFS_CFG   = 5'h00;
    localparam logic [4:0] OFS_SET   = 5'h04;
    localparam logic [4:0] OFS_CLR   = 5'h08;
    localparam logic [4:0] OFS_STAT  = 5'h0C;
    localparam logic [4:0] OFS_A_ADR = 5'h10;
    localparam logic [4:0] OFS_A_CNT = 5'h14;
    localparam logic [4:0] OFS_B_ADR = 5'h18;
    localparam logic [4:0] OFS_B_CNT = 5'h1C;

    // configuration register fields
    localparam int CF_DIR    = 0;
    localparam int CF_ENDIAN = 1;
    localparam int CF_BURST8 = 2;
    localparam int CF_WIDE   = 3;

    // status register, MSB first so bit positions follow the software view
    typedef struct packed {
        logic inuse;
        logic start_b;
        logic done_b;
        logic start_a;
        logic done_a;
        logic err;
        logic ie;
        logic run;
    } stat_t;

    function automatic logic [4:0] burst_bytes(input logic burst8, input logic wide);
        logic [4:0] units;
        units = burst8 ? 5'd8 : 5'd4;
        return wide ? (units << 1) : units;
    endfunction

endpackage

// File: rtl/pdma_slot.sv
module pdma_slot #(
    parameter int AW = 32,
    parameter int CW = 13,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_addr,
    input  logic          wr_cnt,
    input  logic [DW-1:0] wdata,
    input  logic          adv,
    input  logic [4:0]    adv_bytes,
    output logic [AW-1:0] addr_q,
    output logic [CW-1:0] cnt_q
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.addr = st_q.addr + AW'(adv_bytes);
            st_d.cnt  = st_q.cnt - CW'(adv_bytes);
        end
        // a software write wins over a same-cycle advance
        if (wr_addr) st_d.addr = {wdata[AW-1:2], 2'b00};
        if (wr_cnt)  st_d.cnt  = wdata[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_q = st_q.addr;
    assign cnt_q  = st_q.cnt;

    // R5: the engine never advances a slot past its remaining count
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (CW'(adv_bytes) <= st_q.cnt))
        else $error("slot advanced beyond its remaining count");

endmodule

// File: rtl/pdma_status.sv
module pdma_status
    import pingpong_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_we,
    input  logic       clr_we,
    input  logic [6:0] wmask,
    input  logic [1:0] hw_done,
    input  logic       hw_err,
    input  logic       hw_hop,
    output stat_t      stat_q,
    output logic       irq
);

    stat_t stat_d;

    always_comb begin
        stat_d = stat_q;
        if (set_we) stat_d[6:0] = stat_d[6:0] | wmask;
        if (clr_we) stat_d[6:0] = stat_d[6:0] & ~wmask;
        // hardware events take precedence over software writes
        if (hw_done[0]) begin
            stat_d.done_a  = 1'b1;
            stat_d.start_a = 1'b0;
        end
        if (hw_done[1]) begin
            stat_d.done_b  = 1'b1;
            stat_d.start_b = 1'b0;
        end
        if (hw_err) begin
            stat_d.err = 1'b1;
            stat_d.run = 1'b0;
        end
        if (hw_hop) stat_d.inuse = ~stat_q.inuse;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign irq = stat_q.ie & (stat_q.err | stat_q.done_a | stat_q.done_b);

    // R9: an error response leaves the channel stopped with error flagged
    a_r9_error_stops: assert property (@(posedge clk) disable iff (!rst_n)
        hw_err |=> (stat_q.err && !stat_q.run))
        else $error("error response did not stop the channel");

    // R6: slot completion marks done and disarms the slot
    a_r6_done_a_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        hw_done[0] |=> (stat_q.done_a && !stat_q.start_a))
        else $error("slot A completion not recorded");

    a_r6_done_b_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        hw_done[1] |=> (stat_q.done_b && !stat_q.start_b))
        else $error("slot B completion not recorded");

endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
    import pingpong_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [1:0]          start,
    input  logic                inuse,
    input  logic                burst8,
    input  logic                wide,
    input  logic [1:0][AW-1:0]  slot_addr,
    input  logic [1:0][CW-1:0]  slot_cnt,
    input  logic                per_req,
    input  logic                mem_ack,
    input  logic                mem_err,
    output logic                mem_req,
    output logic [AW-1:0]       mem_addr,
    output logic [4:0]          mem_bytes,
    output logic                per_ack,
    output logic [1:0]          adv,
    output logic [4:0]          adv_bytes,
    output logic [1:0]          hw_done,
    output logic                hw_err,
    output logic                hw_hop
);

    typedef struct packed {
        logic          busy;
        logic          sel;
        logic [AW-1:0] addr;
        logic [4:0]    bytes;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [4:0]    bsz, take, fin;
    logic [CW-1:0] cur_cnt, sel_cnt;

    always_comb begin
        eng_d     = eng_q;
        per_ack   = 1'b0;
        adv       = 2'b00;
        adv_bytes = 5'd0;
        hw_done   = 2'b00;
        hw_err    = 1'b0;
        hw_hop    = 1'b0;

        bsz     = burst_bytes(burst8, wide);
        cur_cnt = slot_cnt[inuse];
        take    = (cur_cnt < CW'(bsz)) ? cur_cnt[4:0] : bsz;
        sel_cnt = slot_cnt[eng_q.sel];
        fin     = (sel_cnt < CW'(eng_q.bytes)) ? sel_cnt[4:0] : eng_q.bytes;

        if (!eng_q.busy) begin
            if (run && start[inuse]) begin
                if (cur_cnt == '0) begin
                    // armed empty slot: complete at once
                    hw_done[inuse] = 1'b1;
                    hw_hop         = start[~inuse];
                end else if (per_req) begin
                    eng_d.busy  = 1'b1;
                    eng_d.sel   = inuse;
                    eng_d.addr  = slot_addr[inuse];
                    eng_d.bytes = take;
                end
            end
        end else if (mem_ack) begin
            eng_d.busy = 1'b0;
            if (mem_err) begin
                hw_err = 1'b1;
            end else begin
                per_ack        = 1'b1;
                adv[eng_q.sel] = 1'b1;
                adv_bytes      = fin;
                if (sel_cnt == CW'(fin)) begin
                    hw_done[eng_q.sel] = 1'b1;
                    hw_hop             = start[~eng_q.sel];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign mem_req   = eng_q.busy;
    assign mem_addr  = eng_q.addr;
    assign mem_bytes = eng_q.bytes;

    // R4: a pending request keeps address and size until acknowledged
    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_bytes)))
        else $error("pending burst changed before acknowledge");

    // R4: burst size is never zero nor larger than 16 bytes
    a_r4_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_bytes != 5'd0 && mem_bytes <= 5'd16))
        else $error("illegal burst size");

    // R8: a new burst is only launched while run is set
    a_r8_start_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(run))
        else $error("burst launched while stopped");

endmodule

// File: rtl/pingpong_dma_chan.sv
module pingpong_dma_chan
    import pingpong_dma_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32,
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [4:0]    reg_addr,
    input  logic          reg_we,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          per_req,
    output logic          per_ack,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [4:0]    mem_bytes,
    output logic          mem_write,
    input  logic          mem_ack,
    input  logic          mem_err,
    output logic          irq
);

    localparam int NSLOT = 2;

    logic [DW-1:0] cfg_d, cfg_q;
    stat_t         stat_q;

    logic [NSLOT-1:0][AW-1:0] slot_addr;
    logic [NSLOT-1:0][CW-1:0] slot_cnt;
    logic [NSLOT-1:0]         adv;
    logic [4:0]               adv_bytes;
    logic [NSLOT-1:0]         hw_done;
    logic                     hw_err, hw_hop;

    // configuration register
    always_comb begin
        cfg_d = cfg_q;
        if (reg_we && reg_addr == OFS_CFG) cfg_d = reg_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // buffer slots
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam logic [4:0] OA = (s == 0) ? OFS_A_ADR : OFS_B_ADR;
        localparam logic [4:0] OC = (s == 0) ? OFS_A_CNT : OFS_B_CNT;

        pdma_slot #(.AW(AW), .CW(CW), .DW(DW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_addr   (reg_we && reg_addr == OA),
            .wr_cnt    (reg_we && reg_addr == OC),
            .wdata     (reg_wdata),
            .adv       (adv[s]),
            .adv_bytes (adv_bytes),
            .addr_q    (slot_addr[s]),
            .cnt_q     (slot_cnt[s])
        );
    end

    pdma_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_we  (reg_we && reg_addr == OFS_SET),
        .clr_we  (reg_we && reg_addr == OFS_CLR),
        .wmask   (reg_wdata[6:0]),
        .hw_done (hw_done),
        .hw_err  (hw_err),
        .hw_hop  (hw_hop),
        .stat_q  (stat_q),
        .irq     (irq)
    );

    pdma_engine #(.AW(AW), .CW(CW)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (stat_q.run),
        .start     ({stat_q.start_b, stat_q.start_a}),
        .inuse     (stat_q.inuse),
        .burst8    (cfg_q[CF_BURST8]),
        .wide      (cfg_q[CF_WIDE]),
        .slot_addr (slot_addr),
        .slot_cnt  (slot_cnt),
        .per_req   (per_req),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_bytes (mem_bytes),
        .per_ack   (per_ack),
        .adv       (adv),
        .adv_bytes (adv_bytes),
        .hw_done   (hw_done),
        .hw_err    (hw_err),
        .hw_hop    (hw_hop)
    );

    assign mem_write = cfg_q[CF_DIR];

    // register read mux
    always_comb begin
        case (reg_addr)
            OFS_CFG:   reg_rdata = cfg_q;
            OFS_STAT:  reg_rdata = {{(DW-8){1'b0}}, stat_q};
            OFS_A_ADR: reg_rdata = DW'(slot_addr[0]);
            OFS_A_CNT: reg_rdata = DW'(slot_cnt[0]);
            OFS_B_ADR: reg_rdata = DW'(slot_addr[1]);
            OFS_B_CNT: reg_rdata = DW'(slot_cnt[1]);
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: tb/pingpong_dma_chan_bench.sv
`timescale 1ns/1ps
module pingpong_dma_chan_bench;

    localparam logic [4:0] A_CFG = 5'h00, A_SET = 5'h04, A_CLR = 5'h08, A_STAT = 5'h0C;
    localparam logic [4:0] A_AADR = 5'h10, A_ACNT = 5'h14, A_BADR = 5'h18, A_BCNT = 5'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        per_req = 1'b0;
    logic        per_ack;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [4:0]  mem_bytes;
    logic        mem_write;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    // reference model of the slot sequence
    logic [31:0] m_addr [2];
    int          m_rem  [2];
    bit          m_arm  [2];
    bit          m_sel;
    int          m_bsz;
    bit          m_dir;
    int          bursts;
    bit          err_inject = 1'b0;

    always #10 clk = ~clk;

    pingpong_dma_chan u_pingpong_dma_chan (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
        .per_ack(per_ack), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_bytes(mem_bytes), .mem_write(mem_write), .mem_ack(mem_ack),
        .mem_err(mem_err), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = a;
        #2 d = reg_rdata;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] s;
        int k;
        k = 0;
        s = 32'h50;
        while ((s & 32'h50) != 0 && k < 20000) begin
            rd(A_STAT, s);
            k++;
        end
        chk((s & 32'h50) == 0, tag, s, 0);
    endtask

    task automatic model_normalize();
        for (int i = 0; i < 2; i++) begin
            if (m_arm[m_sel] && m_rem[m_sel] == 0) begin
                m_arm[m_sel] = 1'b0;
                if (m_arm[~m_sel]) m_sel = ~m_sel;
            end
        end
    endtask

    // memory responder and per-burst comparison with the model
    initial begin
        int eb;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            mem_err = 1'b0;
            if (mem_req === 1'b1) begin
                mem_ack = 1'b1;
                mem_err = err_inject;
                err_inject = 1'b0;
                #1;
                chk(per_ack == !mem_err, "R5/R9 per_ack", per_ack, !mem_err);
                if (!mem_err) begin
                    eb = (m_rem[m_sel] < m_bsz) ? m_rem[m_sel] : m_bsz;
                    chk(mem_addr == m_addr[m_sel], "R5 burst address", mem_addr, m_addr[m_sel]);
                    chk(mem_bytes == eb, "R4 burst size", mem_bytes, eb);
                    chk(mem_write == m_dir, "R4 direction", mem_write, m_dir);
                    m_addr[m_sel] = m_addr[m_sel] + eb;
                    m_rem[m_sel]  = m_rem[m_sel] - eb;
                    bursts++;
                    if (m_rem[m_sel] <= 0) begin
                        m_arm[m_sel] = 1'b0;
                        if (m_arm[~m_sel]) m_sel = ~m_sel;
                        model_normalize();
                    end
                end
            end
        end
    end

    function automatic int ceil_div(input int n, input int d);
        return (n + d - 1) / d;
    endfunction

    task automatic set_cfg(input int cfg, input bit dir);
        m_bsz = ((cfg & 1) ? 8 : 4) << ((cfg >> 1) & 1);
        m_dir = dir;
        wr(A_CFG, 32'hA0 | (cfg << 2) | dir);
    endtask

    // both slots armed in one write; slot in use starts first
    task automatic run_case(input int cfg, input bit dir, input int la, input int lb, input bit ie);
        logic [31:0] s, v;
        logic [31:0] aa, ab;
        bit s7;
        int exp_b;
        aa = 32'h2000_0100 + 32'(cfg * 32'h40);
        ab = 32'h3000_0200;
        wr(A_CLR, 32'h7F);
        rd(A_STAT, s);
        s7 = s[7];
        set_cfg(cfg, dir);
        wr(A_AADR, aa); wr(A_ACNT, la);
        wr(A_BADR, ab); wr(A_BCNT, lb);
        m_addr[0] = aa; m_rem[0] = la; m_arm[0] = 1'b1;
        m_addr[1] = ab; m_rem[1] = lb; m_arm[1] = 1'b1;
        m_sel = s7;
        model_normalize();
        bursts = 0;
        exp_b = ceil_div(la, m_bsz) + ceil_div(lb, m_bsz);
        wr(A_SET, 32'h51 | (ie << 1));
        wait_idle("R6 slots drained");
        chk(bursts == exp_b, "R5 burst count", bursts, exp_b);
        rd(A_ACNT, v); chk(v == 0, "R5 slot A count", v, 0);
        rd(A_BCNT, v); chk(v == 0, "R5 slot B count", v, 0);
        rd(A_AADR, v); chk(v == aa + la, "R5 slot A address", v, aa + la);
        rd(A_BADR, v); chk(v == ab + lb, "R5 slot B address", v, ab + lb);
        rd(A_STAT, s);
        chk(s[3] && s[5], "R6 done bits", s, 32'h28);
        chk(s[7] == !s7, "R7 in-use toggled once", s[7], !s7);
        chk(irq == ie, "R10 irq on done", irq, ie);
        wait_cycles(6);
        chk(mem_req == 1'b0 && bursts == exp_b, "R7 idle after both", bursts, exp_b);
        if (ie) begin
            wr(A_CLR, 32'h28);
            #1 chk(irq == 1'b0, "R10 irq cleared", irq, 0);
        end
    endtask

    // arm only the slot in use
    task automatic arm_single(input int len, input logic [31:0] base, output bit sl);
        logic [31:0] s;
        wr(A_CLR, 32'h7F);
        rd(A_STAT, s);
        sl = s[7];
        wr(sl ? A_BADR : A_AADR, base);
        wr(sl ? A_BCNT : A_ACNT, len);
        m_addr[sl] = base; m_rem[sl] = len; m_arm[sl] = 1'b1; m_arm[~sl] = 1'b0;
        m_sel = sl;
        bursts = 0;
    endtask

    initial begin
        logic [31:0] v, s;
        bit sl;
        int b0, k;
        int lens [14] = '{0, 1, 2, 3, 4, 5, 7, 8, 9, 15, 16, 17, 31, 33};

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk(irq == 1'b0, "R1 irq", irq, 0);
        chk(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
        for (int i = 0; i < 8; i++) begin
            rd(5'(i * 4), v);
            chk(v == 0, "R1 register zero", v, 0);
        end

        // R2 register storage
        wr(A_CFG, 32'hDEAD_BEE0);
        rd(A_CFG, v); chk(v == 32'hDEAD_BEE0, "R2 cfg readback", v, 32'hDEAD_BEE0);
        wr(A_AADR, 32'h1234_5677);
        rd(A_AADR, v); chk(v == 32'h1234_5674, "R2 A address aligned", v, 32'h1234_5674);
        wr(A_BADR, 32'hFFFF_FFFF);
        rd(A_BADR, v); chk(v == 32'hFFFF_FFFC, "R2 B address aligned", v, 32'hFFFF_FFFC);
        wr(A_ACNT, 32'hFFFF);
        rd(A_ACNT, v); chk(v == 32'h1FFF, "R2 A count width", v, 32'h1FFF);
        wr(A_BCNT, 32'h2005);
        rd(A_BCNT, v); chk(v == 32'h0005, "R2 B count width", v, 5);

        // R3 set / clear views
        wr(A_SET, 32'h42);
        rd(A_STAT, v); chk(v == 32'h42, "R3 set view", v, 32'h42);
        wr(A_SET, 32'h00);
        rd(A_STAT, v); chk(v == 32'h42, "R3 zero set no effect", v, 32'h42);
        wr(A_CLR, 32'h00);
        rd(A_STAT, v); chk(v == 32'h42, "R3 zero clear no effect", v, 32'h42);
        wr(A_CLR, 32'h02);
        rd(A_STAT, v); chk(v == 32'h40, "R3 clear view", v, 32'h40);
        wr(A_SET, 32'h80);
        rd(A_STAT, v); chk(v == 32'h40, "R3 in-use not writable", v, 32'h40);
        rd(A_SET, v); chk(v == 0, "R3 set view reads zero", v, 0);
        wr(A_CLR, 32'h7F);
        rd(A_STAT, v); chk(v == 0, "R3 clear all", v, 0);

        per_req = 1'b1;

        // sweep: every burst setting against many slot lengths
        for (int c = 0; c < 4; c++) begin
            for (int i = 0; i < 14; i++) begin
                run_case(c, bit'(c ^ i), lens[i], lens[(i + 3) % 14], bit'(i));
            end
        end

        // largest count with widest burst
        run_case(3, 1'b0, 32'h1FFF, 4, 1'b1);

        // R5 no burst without a peripheral request
        per_req = 1'b0;
        set_cfg(0, 1'b0);
        arm_single(8, 32'h4000_0000, sl);
        wr(A_SET, sl ? 32'h41 : 32'h11);
        wait_cycles(10);
        chk(bursts == 0 && mem_req == 1'b0, "R5 gated by per_req", bursts, 0);
        per_req = 1'b1;
        wait_idle("R5 drained after per_req");
        chk(bursts == 2, "R5 bursts after per_req", bursts, 2);
        rd(A_STAT, s);
        chk(s[7] == sl, "R7 no hop to unarmed slot", s[7], sl);
        wait_cycles(6);
        chk(mem_req == 1'b0 && bursts == 2, "R7 idle when other unarmed", bursts, 2);

        // R8 pause and resume
        arm_single(64, 32'h5000_0040, sl);
        wr(A_SET, sl ? 32'h41 : 32'h11);
        k = 0;
        while (bursts < 3 && k < 200) begin @(negedge clk); k++; end
        wr(A_CLR, 32'h01);
        wait_cycles(2);
        b0 = bursts;
        wait_cycles(10);
        chk(bursts == b0 && mem_req == 1'b0, "R8 paused", bursts, b0);
        rd(sl ? A_BCNT : A_ACNT, v);
        chk(v == 64 - b0 * 4, "R8 count held in pause", v, 64 - b0 * 4);
        rd(sl ? A_BADR : A_AADR, v);
        chk(v == 32'h5000_0040 + b0 * 4, "R8 address held in pause", v, 32'h5000_0040 + b0 * 4);
        wr(A_SET, 32'h01);
        wait_idle("R8 resumed to end");
        chk(bursts == 16, "R8 total bursts", bursts, 16);
        rd(sl ? A_BADR : A_AADR, v);
        chk(v == 32'h5000_0080, "R8 final address", v, 32'h5000_0080);

        // R9 error response
        arm_single(16, 32'h6000_0000, sl);
        err_inject = 1'b1;
        wr(A_SET, sl ? 32'h43 : 32'h13);
        k = 0;
        s = 0;
        while (!s[2] && k < 200) begin rd(A_STAT, s); k++; end
        chk(s[2] == 1'b1 && s[0] == 1'b0, "R9 error set and run cleared", s, 32'h04);
        rd(sl ? A_BCNT : A_ACNT, v);
        chk(v == 16, "R9 no advance on error", v, 16);
        chk(bursts == 0, "R9 no good burst", bursts, 0);
        chk(irq == 1'b1, "R10 irq on error", irq, 1);
        wr(A_CLR, 32'h04);
        #1 chk(irq == 1'b0, "R10 irq after error clear", irq, 0);
        wr(A_SET, 32'h01);
        wait_idle("R9 recovery");
        chk(bursts == 4, "R9 bursts after recovery", bursts, 4);

        // R10 enable gates the interrupt
        rd(A_STAT, s);
        chk(irq == (s[1] & (s[2] | s[3] | s[5])), "R10 irq function", irq, s[1] & (s[2] | s[3] | s[5]));
        wr(A_CLR, 32'h02);
        #1 chk(irq == 1'b0, "R10 irq masked", irq, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule